// File: doc/BRIEF.md
# Pulse Width Time-to-Digital Converter

This block measures how long an asynchronous pulse stays high by counting periods of a fast measurement clock. It is meant to follow an external voltage-to-time stage, so each pulse width stands for an analog level. One code is produced for each pulse. The code step is one period of the measurement clock, for example about 4.16 ns at 240 MHz. Lowering the clock frequency widens the range of measurable widths, and the logic does not change.

The pulse first goes through a synchronizer. The clock that reaches this block may only settle a few cycles after the pulse edge, so some cycles are missed before counting begins. To make up for them, each measurement starts from a preset latency offset, which is 3 by default. A pulse that is shorter than the offset still gets a defined code: the plain count of cycles it was seen high, with a separate flag raised. A count that would go past the largest code stops at that code and raises an overflow flag for that measurement.

Top module: `pulse_width_tdc`

## Requirements
- R1: A synchronous active-high reset clears `result`, `done`, `overflow` and `short_pulse` to 0.
- R2: For a pulse seen high for H measurement-clock cycles with H >= 3, `result` equals H + 3 and `short_pulse` is 0.
- R3: For H < 3 (H = 1 or 2), `result` equals H and `short_pulse` is 1. H = 3 is not short and gives 6.
- R4: When H + 3 exceeds 8191, `result` is 8191 and `overflow` is 1. H = 8188 gives 8191 with `overflow` 0.
- R5: `done` is high for exactly one cycle per pulse. It rises on the third rising clock edge after the hit input goes low, and `result` and the flags update in that same cycle.
- R6: Between completions, `result`, `overflow` and `short_pulse` hold their values, and no `done` occurs while the hit input stays low.
- R7: Every measurement starts afresh from the offset. An overflow from one pulse does not carry into the next pulse's flags or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_async | input | 1 | Asynchronous pulse to be measured |
| result | output | 13 | Width code of the last completed pulse |
| done | output | 1 | One-cycle strobe marking a new result |
| overflow | output | 1 | Last result saturated at full scale |
| short_pulse | output | 1 | Last pulse was shorter than the offset |

## Verification
The hardest condition to reach is saturation. It only happens when a pulse stays high for about eight thousand cycles, and the boundary sits exactly between H = 8188 and H = 8189. The stimulus therefore holds the hit input for an exact number of clock periods around that boundary, then follows at once with a short pulse to show that the overflow flag clears. The short-pulse path is reached the same way: pulses of one and two periods are applied, each driven on the falling clock edge so that the synchronized width is exact.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int TDC_CNT_W  = 13;
  localparam int TDC_PRESET = 3;
  localparam int TDC_SYNC   = 2;
endpackage

// File: rtl/tdc_hit_sync.sv
module tdc_hit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_async,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= hit_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], hit_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= level;
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/tdc_width_counter.sv
module tdc_width_counter #(
  parameter int CNT_W  = 13,
  parameter int PRESET = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  output logic [CNT_W-1:0] count,
  output logic             sat
);
  localparam logic [CNT_W-1:0] FULL  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(PRESET + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      sat   <= 1'b0;
    end else if (start) begin
      count <= FIRST;
      sat   <= 1'b0;
    end else if (run) begin
      if (count == FULL) sat   <= 1'b1;
      else               count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_result_reg.sv
module tdc_result_reg #(
  parameter int CNT_W  = 13,
  parameter int PRESET = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CNT_W-1:0] count,
  input  logic             sat,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overflow,
  output logic             short_pulse
);
  localparam logic [CNT_W-1:0] OFFS  = CNT_W'(PRESET);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 * PRESET);

  logic is_short;
  assign is_short = (count < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      done        <= 1'b0;
      overflow    <= 1'b0;
      short_pulse <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        result      <= is_short ? (count - OFFS) : count;
        overflow    <= sat;
        short_pulse <= is_short;
      end
    end
  end
endmodule

// File: rtl/pulse_width_tdc.sv
module pulse_width_tdc
  import tdc_pkg::*;
#(
  parameter int CNT_W  = TDC_CNT_W,
  parameter int PRESET = TDC_PRESET,
  parameter int SYNC   = TDC_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_async,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overflow,
  output logic             short_pulse
);
  logic             hit_lvl, hit_rise, hit_fall;
  logic [CNT_W-1:0] cnt;
  logic             cnt_sat;

  tdc_hit_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .hit_async(hit_async),
    .level(hit_lvl), .rise(hit_rise), .fall(hit_fall)
  );

  tdc_width_counter #(.CNT_W(CNT_W), .PRESET(PRESET)) u_cnt (
    .clk(clk), .rst(rst), .start(hit_rise), .run(hit_lvl),
    .count(cnt), .sat(cnt_sat)
  );

  tdc_result_reg #(.CNT_W(CNT_W), .PRESET(PRESET)) u_res (
    .clk(clk), .rst(rst), .capture(hit_fall), .count(cnt), .sat(cnt_sat),
    .result(result), .done(done), .overflow(overflow), .short_pulse(short_pulse)
  );
endmodule

// File: rtl/pulse_width_tdc_chk.sv
module pulse_width_tdc_chk #(
  parameter int CNT_W  = 13,
  parameter int PRESET = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] result,
  input logic             done,
  input logic             overflow,
  input logic             short_pulse
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && !done && !overflow && !short_pulse)); // R1
  AST_NORMAL_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (done && !short_pulse) |-> (result >= CNT_W'(2 * PRESET))); // R2
  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (rst)
    short_pulse |-> (result < CNT_W'(PRESET) && !overflow)); // R3
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (result == FULL)); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(result) && $stable(overflow) && $stable(short_pulse))); // R6
endmodule

bind pulse_width_tdc pulse_width_tdc_chk #(.CNT_W(CNT_W), .PRESET(PRESET)) u_chk (
  .clk(clk), .rst(rst), .result(result), .done(done),
  .overflow(overflow), .short_pulse(short_pulse)
);

// File: tb/pulse_width_tdc_bench.sv
module pulse_width_tdc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int VH   [NV] = '{1, 2, 3, 4, 10, 100, 500, 37};
  localparam int VRES [NV] = '{1, 2, 6, 7, 13, 103, 503, 40};
  localparam int VSH  [NV] = '{1, 1, 0, 0, 0, 0, 0, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit = 1'b0;
  logic [12:0] result;
  logic        done, overflow, short_pulse;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_width_tdc u_pulse_width_tdc (
    .clk(clk), .rst(rst), .hit_async(hit), .result(result),
    .done(done), .overflow(overflow), .short_pulse(short_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a pulse of h clock periods, return the negedge index at which done was seen
  task automatic pulse(input int h, output int lat);
    hit = 1'b1;
    repeat (h) @(negedge clk);
    hit = 1'b0;
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (done) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic measure(input int h, input int er, input int es, input int eo, input string req);
    int lat;
    pulse(h, lat);
    check(lat == 3, "R5 latency", lat, 3);
    check(result == 13'(er), req, result, er);
    check(short_pulse == es[0], {req, " short"}, short_pulse, es);
    check(overflow == eo[0], {req, " ovf"}, overflow, eo);
    @(negedge clk);
    check(done == 1'b0, "R5 single", done, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int lat;
    logic [12:0] held;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(result == 0 && !done && !overflow && !short_pulse, "R1", result, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++)
      measure(VH[i], VRES[i], VSH[i], 0, VSH[i] ? "R3" : "R2");

    // R4 saturation boundary
    measure(8188, 8191, 0, 0, "R4 edge");
    measure(8189, 8191, 0, 1, "R4 sat");
    measure(9000, 8191, 0, 1, "R4 long");
    // R7 fresh start after overflow
    measure(2, 2, 1, 0, "R7 short");
    measure(8189, 8191, 0, 1, "R4 sat2");
    measure(5, 8, 0, 0, "R7 normal");

    // R6 hold while idle
    held = result;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0, "R6 no done", lat, 0);
    check(result == held && !overflow && !short_pulse, "R6 hold", result, held);

    // R1 reset mid-stream clears
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(result == 0 && !done && !overflow && !short_pulse, "R1 again", result, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    measure(1, 1, 1, 0, "R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule